// File: doc/BRIEF.md
# Prioritised Group Request Scheduler

This block decides which register group a save/restore engine works on next. There are sixteen groups. Each one can be asked to save or to restore by two sources: a power controller, which drives one request vector for save and one for restore, and software trigger vectors of the same shape. A request is held in one of four pending bitmaps, split by source and by kind. Every bitmap can be read at the ports.

While the engine is idle, the scheduler looks at every enabled group that has something pending and starts the best candidate. The first key is the group's 4-bit priority for that kind of operation, where a lower value wins. At equal priority a hardware request beats a software one, and after that the lower group index wins. The chosen group, its operation and its source stay on the run outputs until the engine reports completion. Completion clears the pending bit that was served. A run that came from software also raises a done pulse.

If one group ever holds a save and a restore at the same time, from any mix of sources, the scheduler drops both and raises a conflict pulse. A global input blocks the capture of new power-controller requests.

Top module: `grp_req_sched`

## Requirements
- R1: There are four pending bitmaps: hardware save, hardware restore, software save and software restore. A request bit for group g sets bit g of the matching bitmap, and the bit is visible one cycle after the request. One group may be pending from both sources for the same kind. Completion clears only the bit of the source that was served.
- R2: Among eligible groups, the lowest priority value runs first. A save takes the value from `save_prio[4g+3:4g]` and a restore takes it from `restore_prio[4g+3:4g]`.
- R3: Among equal priorities, the lower group index runs first.
- R4: At equal priority a hardware-sourced request runs before a software-sourced one. This also holds inside one group that is pending from both sources. `run_from_sw` is 1 for software and 0 for hardware.
- R5: While `hw_req_disable` is 1, hardware request bits set no pending bit. Software triggers are not affected.
- R6: A group whose `grp_enable` bit is 0 is never started. Its pending bits are kept, and it becomes eligible again once it is re-enabled.
- R7: If a group would hold a save (either source) and a restore (either source) together, all four of its pending bits are cleared. `conflict_err` is then 1 for exactly one cycle.
- R8: `sw_done` is 1 for one cycle right after the completion of a software-sourced run. It stays 0 after a hardware-sourced run.
- R9: A running group is never pre-empted. `run_valid`, `run_group`, `run_restore` and `run_from_sw` hold until `exec_done` is seen. `run_restore` is 1 for restore and 0 for save.
- R10: When the engine is idle, a run starts one cycle after its pending bit becomes visible. `run_valid` is low for the one cycle after a completion.
- R11: If a new request for a bitmap bit arrives in the same cycle that completion clears that bit, the bit stays set.
- R12: After reset all pending bitmaps, `run_valid`, `sw_done` and `conflict_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_disable | input | 1 | Blocks capture of power-controller requests |
| hw_save_req | input | 16 | Power-controller save request per group |
| hw_restore_req | input | 16 | Power-controller restore request per group |
| sw_save_trig | input | 16 | Software save trigger per group |
| sw_restore_trig | input | 16 | Software restore trigger per group |
| grp_enable | input | 16 | Per-group scheduling enable |
| save_prio | input | 64 | Save priority, 4 bits per group, field g at [4g+3:4g] |
| restore_prio | input | 64 | Restore priority, 4 bits per group, field g at [4g+3:4g] |
| exec_done | input | 1 | Engine reports that the current group has finished |
| run_valid | output | 1 | A group is handed to the engine |
| run_group | output | 4 | Index of the running group |
| run_restore | output | 1 | 1 = restore, 0 = save |
| run_from_sw | output | 1 | 1 = software-sourced run, 0 = hardware-sourced run |
| pend_hw_save | output | 16 | Hardware save pending bitmap |
| pend_hw_restore | output | 16 | Hardware restore pending bitmap |
| pend_sw_save | output | 16 | Software save pending bitmap |
| pend_sw_restore | output | 16 | Software restore pending bitmap |
| sw_done | output | 1 | One-cycle pulse after a software-sourced run completes |
| conflict_err | output | 1 | One-cycle pulse when a save/restore clash is dropped |

## Verification
Completion of a run and a fresh request for the very bit that completion clears can land on the same clock edge. The bench provokes this by raising `exec_done` and the matching software trigger together. It then requires the bit to remain set and the same group to run a second time. A second collision also gets a check: a request that is pending but held back by a disabled group, followed by an opposite-kind request for that group. Here the bench requires the conflict pulse and all of that group's pending bits to be clear.

// File: rtl/grp_sched_pkg.sv
package grp_sched_pkg;

    localparam int unsigned GROUPS = 16;
    localparam int unsigned PRIO_W = 4;

    typedef enum logic { OP_SAVE = 1'b0, OP_RESTORE = 1'b1 } op_e;
    typedef enum logic { SRC_HW = 1'b0, SRC_SW = 1'b1 } src_e;

    // bitmap slot = {source, operation}
    localparam int unsigned KI_HW_SAVE = 0;
    localparam int unsigned KI_HW_REST = 1;
    localparam int unsigned KI_SW_SAVE = 2;
    localparam int unsigned KI_SW_REST = 3;

    // smaller key wins: priority first, then hardware before software
    function automatic logic [PRIO_W:0] rank_key(input logic [PRIO_W-1:0] prio, input src_e src);
        return {prio, src == SRC_SW};
    endfunction

endpackage

// File: rtl/gs_pending.sv
module gs_pending
    import grp_sched_pkg::*;
#(
    parameter int unsigned NGRP = GROUPS,
    localparam int unsigned GW = $clog2(NGRP)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hw_block,
    input  logic [3:0][NGRP-1:0]  req_in,
    input  logic                  clr_valid,
    input  logic [GW-1:0]         clr_grp,
    input  logic [1:0]            clr_kind,
    output logic [3:0][NGRP-1:0]  pend_q,
    output logic                  clash_q
);

    logic [3:0][NGRP-1:0] nxt;
    logic [NGRP-1:0]      clr_onehot;
    logic [NGRP-1:0]      save_any;
    logic [NGRP-1:0]      rest_any;
    logic [NGRP-1:0]      clash;

    assign clr_onehot = clr_valid ? (NGRP'(1) << clr_grp) : '0;

    for (genvar k = 0; k < 4; k++) begin : g_kind
        logic [NGRP-1:0] arrive;
        if (k < 2) begin : g_hw
            assign arrive = hw_block ? '0 : req_in[k];
        end else begin : g_sw
            assign arrive = req_in[k];
        end
        // a new arrival overrides a same-cycle completion clear
        assign nxt[k] = (pend_q[k] & ~((clr_kind == 2'(k)) ? clr_onehot : '0)) | arrive;
    end

    assign save_any = nxt[KI_HW_SAVE] | nxt[KI_SW_SAVE];
    assign rest_any = nxt[KI_HW_REST] | nxt[KI_SW_REST];
    assign clash    = save_any & rest_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            clash_q <= 1'b0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                pend_q[k] <= nxt[k] & ~clash;
            end
            clash_q <= |clash;
        end
    end

endmodule

// File: rtl/gs_arbiter.sv
module gs_arbiter
    import grp_sched_pkg::*;
#(
    parameter int unsigned NGRP = GROUPS,
    localparam int unsigned GW = $clog2(NGRP)
) (
    input  logic [3:0][NGRP-1:0]   pend,
    input  logic [NGRP-1:0]        grp_en,
    input  logic [NGRP*PRIO_W-1:0] save_prio,
    input  logic [NGRP*PRIO_W-1:0] rest_prio,
    output logic                   sel_valid,
    output logic [GW-1:0]          sel_grp,
    output op_e                    sel_op,
    output src_e                   sel_src
);

    always_comb begin
        logic              has_s;
        logic              has_r;
        logic              hw_hit;
        logic [PRIO_W-1:0] pr;
        logic [PRIO_W:0]   key;
        logic [PRIO_W:0]   best;
        sel_valid = 1'b0;
        sel_grp   = '0;
        sel_op    = OP_SAVE;
        sel_src   = SRC_HW;
        best      = '1;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int g = 0; g < NGRP; g++) begin
            has_s  = grp_en[g] & (pend[KI_HW_SAVE][g] | pend[KI_SW_SAVE][g]);
            has_r  = grp_en[g] & (pend[KI_HW_REST][g] | pend[KI_SW_REST][g]);
            hw_hit = has_s ? pend[KI_HW_SAVE][g] : pend[KI_HW_REST][g];
            pr     = has_s ? save_prio[g*PRIO_W +: PRIO_W] : rest_prio[g*PRIO_W +: PRIO_W];
            key    = rank_key(pr, hw_hit ? SRC_HW : SRC_SW);
            if ((has_s | has_r) && (!sel_valid || key < best)) begin
                sel_valid = 1'b1;
                best      = key;
                sel_grp   = GW'(g);
                sel_op    = has_s ? OP_SAVE : OP_RESTORE;
                sel_src   = hw_hit ? SRC_HW : SRC_SW;
            end
        end
    end

endmodule

// File: rtl/gs_runner.sv
module gs_runner
    import grp_sched_pkg::*;
#(
    parameter int unsigned NGRP = GROUPS,
    localparam int unsigned GW = $clog2(NGRP)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_valid,
    input  logic [GW-1:0] sel_grp,
    input  op_e           sel_op,
    input  src_e          sel_src,
    input  logic          done,
    output logic          busy_q,
    output logic [GW-1:0] grp_q,
    output op_e           op_q,
    output src_e          src_q,
    output logic          finish,
    output logic          sw_done_q
);

    assign finish = busy_q & done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            grp_q     <= '0;
            op_q      <= OP_SAVE;
            src_q     <= SRC_HW;
            sw_done_q <= 1'b0;
        end else begin
            sw_done_q <= 1'b0;
            if (busy_q) begin
                if (done) begin
                    busy_q    <= 1'b0;
                    sw_done_q <= (src_q == SRC_SW);
                end
            end else if (sel_valid) begin
                busy_q <= 1'b1;
                grp_q  <= sel_grp;
                op_q   <= sel_op;
                src_q  <= sel_src;
            end
        end
    end

endmodule

// File: rtl/grp_req_sched.sv
module grp_req_sched
    import grp_sched_pkg::*;
#(
    parameter int unsigned NGRP = GROUPS,
    localparam int unsigned GW = $clog2(NGRP)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hw_req_disable,
    input  logic [NGRP-1:0]        hw_save_req,
    input  logic [NGRP-1:0]        hw_restore_req,
    input  logic [NGRP-1:0]        sw_save_trig,
    input  logic [NGRP-1:0]        sw_restore_trig,
    input  logic [NGRP-1:0]        grp_enable,
    input  logic [NGRP*PRIO_W-1:0] save_prio,
    input  logic [NGRP*PRIO_W-1:0] restore_prio,
    input  logic                   exec_done,
    output logic                   run_valid,
    output logic [GW-1:0]          run_group,
    output logic                   run_restore,
    output logic                   run_from_sw,
    output logic [NGRP-1:0]        pend_hw_save,
    output logic [NGRP-1:0]        pend_hw_restore,
    output logic [NGRP-1:0]        pend_sw_save,
    output logic [NGRP-1:0]        pend_sw_restore,
    output logic                   sw_done,
    output logic                   conflict_err
);

    logic [3:0][NGRP-1:0] req_vec;
    logic [3:0][NGRP-1:0] pend;
    logic                 sel_valid;
    logic [GW-1:0]        sel_grp;
    op_e                  sel_op;
    src_e                 sel_src;
    op_e                  cur_op;
    src_e                 cur_src;
    logic                 finish;

    assign req_vec = {sw_restore_trig, sw_save_trig, hw_restore_req, hw_save_req};

    gs_pending #(.NGRP(NGRP)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .hw_block  (hw_req_disable),
        .req_in    (req_vec),
        .clr_valid (finish),
        .clr_grp   (run_group),
        .clr_kind  ({cur_src == SRC_SW, cur_op == OP_RESTORE}),
        .pend_q    (pend),
        .clash_q   (conflict_err)
    );

    gs_arbiter #(.NGRP(NGRP)) u_arb (
        .pend      (pend),
        .grp_en    (grp_enable),
        .save_prio (save_prio),
        .rest_prio (restore_prio),
        .sel_valid (sel_valid),
        .sel_grp   (sel_grp),
        .sel_op    (sel_op),
        .sel_src   (sel_src)
    );

    gs_runner #(.NGRP(NGRP)) u_run (
        .clk       (clk),
        .rst       (rst),
        .sel_valid (sel_valid),
        .sel_grp   (sel_grp),
        .sel_op    (sel_op),
        .sel_src   (sel_src),
        .done      (exec_done),
        .busy_q    (run_valid),
        .grp_q     (run_group),
        .op_q      (cur_op),
        .src_q     (cur_src),
        .finish    (finish),
        .sw_done_q (sw_done)
    );

    assign run_restore     = (cur_op == OP_RESTORE);
    assign run_from_sw     = (cur_src == SRC_SW);
    assign pend_hw_save    = pend[KI_HW_SAVE];
    assign pend_hw_restore = pend[KI_HW_REST];
    assign pend_sw_save    = pend[KI_SW_SAVE];
    assign pend_sw_restore = pend[KI_SW_REST];

endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
    parameter int unsigned NGRP = 16,
    localparam int unsigned GW = $clog2(NGRP)
) (
    input logic            clk,
    input logic            rst,
    input logic            hw_req_disable,
    input logic [NGRP-1:0] grp_enable,
    input logic            exec_done,
    input logic            run_valid,
    input logic [GW-1:0]   run_group,
    input logic            run_restore,
    input logic            run_from_sw,
    input logic [NGRP-1:0] pend_hw_save,
    input logic [NGRP-1:0] pend_hw_restore,
    input logic [NGRP-1:0] pend_sw_save,
    input logic [NGRP-1:0] pend_sw_restore,
    input logic            sw_done
);

    AST_RUN_HELD: assert property (@(posedge clk) disable iff (rst)
        run_valid && !exec_done |=> run_valid && $stable(run_group) && $stable(run_restore) && $stable(run_from_sw)); // R9

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        ((pend_hw_save | pend_sw_save) & (pend_hw_restore | pend_sw_restore)) == '0); // R7

    AST_HW_GATED: assert property (@(posedge clk) disable iff (rst)
        hw_req_disable |=> ((pend_hw_save & ~$past(pend_hw_save)) == '0) &&
                           ((pend_hw_restore & ~$past(pend_hw_restore)) == '0)); // R5

    AST_SWDONE_SRC: assert property (@(posedge clk) disable iff (rst)
        sw_done |-> $past(run_valid && exec_done && run_from_sw)); // R8

    AST_START_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(run_valid) |-> ($past(grp_enable) & (NGRP'(1) << run_group)) != '0); // R6

endmodule

bind grp_req_sched gs_checker #(.NGRP(NGRP)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .hw_req_disable  (hw_req_disable),
    .grp_enable      (grp_enable),
    .exec_done       (exec_done),
    .run_valid       (run_valid),
    .run_group       (run_group),
    .run_restore     (run_restore),
    .run_from_sw     (run_from_sw),
    .pend_hw_save    (pend_hw_save),
    .pend_hw_restore (pend_hw_restore),
    .pend_sw_save    (pend_sw_save),
    .pend_sw_restore (pend_sw_restore),
    .sw_done         (sw_done)
);

// File: tb/tb_grp_req_sched.sv
module tb_grp_req_sched;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_req_disable = 1'b0;
    logic [15:0] hw_save_req = '0, hw_restore_req = '0;
    logic [15:0] sw_save_trig = '0, sw_restore_trig = '0;
    logic [15:0] grp_enable = '1;
    logic [63:0] save_prio = '0, restore_prio = '0;
    logic        exec_done = 1'b0;
    logic        run_valid, run_restore, run_from_sw, sw_done, conflict_err;
    logic [3:0]  run_group;
    logic [15:0] pend_hw_save, pend_hw_restore, pend_sw_save, pend_sw_restore;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit conflict_seen;

    grp_req_sched dut (.*);

    always #2 clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] ss, input logic [15:0] sr,
                         input logic [15:0] hs, input logic [15:0] hr);
        sw_save_trig = ss; sw_restore_trig = sr; hw_save_req = hs; hw_restore_req = hr;
        @(negedge clk);
        sw_save_trig = '0; sw_restore_trig = '0; hw_save_req = '0; hw_restore_req = '0;
        conflict_seen = conflict_err;
    endtask

    task automatic serve(output int g, output int op, output int sw, output int swd);
        int n = 0;
        while (!run_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (!run_valid) begin
            chk(1'b0, "R10 run never started", 0, 1);
            g = -1; op = -1; sw = -1; swd = -1;
            return;
        end
        g = int'(run_group); op = int'(run_restore); sw = int'(run_from_sw);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        swd = int'(sw_done);
    endtask

    function automatic logic [3:0] prio_of(input int pat, input int g);
        case (pat)
            0: return 4'd0;
            1: return 4'(15 - g);
            2: return 4'((g * 5 + 3) % 16);
            3: return 4'(g % 3);
            default: return 4'((g * 11 + 7) % 16);
        endcase
    endfunction

    // runs all 16 groups of one kind and compares the order against a computed ranking
    task automatic sweep(input int pat, input bit rest, input bit use_hw);
        bit [15:0] used = '0;
        int g, op, sw, swd;
        for (int i = 0; i < 16; i++) begin
            if (rest) restore_prio[i*4 +: 4] = prio_of(pat, i);
            else      save_prio[i*4 +: 4] = prio_of(pat, i);
        end
        if (rest && use_hw)  pulse('0, '0, '0, 16'hFFFF);
        else if (rest)       pulse('0, 16'hFFFF, '0, '0);
        else if (use_hw)     pulse('0, '0, 16'hFFFF, '0);
        else                 pulse(16'hFFFF, '0, '0, '0);
        for (int r = 0; r < 16; r++) begin
            int best = -1;
            for (int c = 0; c < 16; c++) begin
                if (!used[c] && (best < 0 || prio_of(pat, c) < prio_of(pat, best))) best = c;
            end
            used[best] = 1'b1;
            serve(g, op, sw, swd);
            chk(g == best, rest ? "R2/R3 restore order" : "R2/R3 save order", g, best);
            chk(op == int'(rest) && sw == int'(!use_hw), "R2 op/source", op * 2 + sw, int'(rest) * 2 + int'(!use_hw));
            chk(swd == int'(!use_hw), "R8 done pulse", swd, int'(!use_hw));
        end
        chk(pend_hw_save == 0 && pend_sw_save == 0 && pend_hw_restore == 0 && pend_sw_restore == 0,
            "R1 drained", int'(pend_sw_save | pend_hw_save), 0);
    endtask

    initial begin
        int g, op, sw, swd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pend_hw_save == 0 && pend_hw_restore == 0 && pend_sw_save == 0 && pend_sw_restore == 0,
            "R12 pending after reset", int'(pend_sw_save), 0);
        chk(!run_valid && !sw_done && !conflict_err, "R12 outputs after reset", int'(run_valid), 0);

        for (int p = 0; p < 5; p++) sweep(p, 1'b0, 1'b0);
        save_prio = '0;
        sweep(2, 1'b1, 1'b1);
        sweep(4, 1'b1, 1'b0);
        restore_prio = '0;

        // R10 timing: pending next cycle, run the cycle after
        pulse(16'h0020, '0, '0, '0);
        chk(pend_sw_save == 16'h0020 && !run_valid, "R10 pending before start", int'(pend_sw_save), 32);
        @(negedge clk);
        chk(run_valid && run_group == 4'd5, "R10 start one cycle later", int'(run_group), 5);
        serve(g, op, sw, swd);
        chk(!run_valid, "R10 idle after completion", int'(run_valid), 0);

        // R4 hardware beats software at equal priority
        pulse(16'h0004, '0, 16'h0200, '0);
        serve(g, op, sw, swd);
        chk(g == 9 && sw == 0 && swd == 0, "R4 hw first", g, 9);
        serve(g, op, sw, swd);
        chk(g == 2 && sw == 1 && swd == 1, "R4 sw second", g, 2);

        // R1/R4 same group pending from both sources
        pulse(16'h0040, '0, 16'h0040, '0);
        chk(pend_hw_save == 16'h0040 && pend_sw_save == 16'h0040, "R1 both bitmaps", int'(pend_hw_save), 64);
        serve(g, op, sw, swd);
        chk(g == 6 && sw == 0, "R4 hw within group", g * 2 + sw, 12);
        chk(pend_hw_save == 0 && pend_sw_save == 16'h0040, "R1 only served bit cleared", int'(pend_sw_save), 64);
        serve(g, op, sw, swd);
        chk(g == 6 && sw == 1, "R1 sw served later", g * 2 + sw, 13);

        // R5 hardware disable
        hw_req_disable = 1'b1;
        pulse(16'h0100, '0, 16'h0002, 16'h0001);
        chk(pend_hw_save == 0 && pend_hw_restore == 0, "R5 hw ignored", int'(pend_hw_save | pend_hw_restore), 0);
        chk(pend_sw_save == 16'h0100, "R5 sw still taken", int'(pend_sw_save), 256);
        serve(g, op, sw, swd);
        chk(g == 8, "R5 sw runs", g, 8);
        hw_req_disable = 1'b0;

        // R6 disabled group kept pending but not started
        grp_enable = 16'hFFF7;
        pulse(16'h0018, '0, '0, '0);
        serve(g, op, sw, swd);
        chk(g == 4, "R6 enabled group runs", g, 4);
        repeat (5) @(negedge clk);
        chk(!run_valid && pend_sw_save == 16'h0008, "R6 disabled group held", int'(pend_sw_save), 8);
        grp_enable = '1;
        serve(g, op, sw, swd);
        chk(g == 3, "R6 runs after re-enable", g, 3);

        // R7 conflict on a held-back group and in one cycle
        grp_enable = 16'hFF7F;
        pulse(16'h0080, '0, '0, '0);
        chk(pend_sw_save == 16'h0080 && !conflict_seen, "R7 save held", int'(pend_sw_save), 128);
        pulse('0, '0, '0, 16'h0080);
        chk(conflict_seen, "R7 conflict flagged", int'(conflict_seen), 1);
        chk(pend_sw_save == 0 && pend_hw_restore == 0, "R7 both dropped", int'(pend_sw_save | pend_hw_restore), 0);
        @(negedge clk);
        chk(!conflict_err, "R7 one-cycle pulse", int'(conflict_err), 0);
        grp_enable = '1;
        pulse(16'h0400, 16'h0400, '0, '0);
        chk(conflict_seen && pend_sw_save == 0 && pend_sw_restore == 0, "R7 same-cycle clash",
            int'(pend_sw_save | pend_sw_restore), 0);
        repeat (3) @(negedge clk);
        chk(!run_valid, "R7 nothing runs", int'(run_valid), 0);

        // R9 no pre-emption
        save_prio[10*4 +: 4] = 4'd15;
        save_prio[0 +: 4] = 4'd0;
        pulse(16'h0400, '0, '0, '0);
        @(negedge clk);
        pulse(16'h0001, '0, '0, '0);
        for (int k = 0; k < 6; k++) begin
            chk(run_valid && run_group == 4'd10, "R9 run held", int'(run_group), 10);
            @(negedge clk);
        end
        serve(g, op, sw, swd);
        chk(g == 10, "R9 original completes", g, 10);
        serve(g, op, sw, swd);
        chk(g == 0, "R9 waiting group next", g, 0);
        save_prio = '0;

        // R11 completion and re-trigger in the same cycle
        pulse(16'h1000, '0, '0, '0);
        @(negedge clk);
        chk(run_valid && run_group == 4'd12, "R11 running", int'(run_group), 12);
        exec_done = 1'b1;
        sw_save_trig = 16'h1000;
        @(negedge clk);
        exec_done = 1'b0;
        sw_save_trig = '0;
        chk(pend_sw_save == 16'h1000, "R11 bit kept", int'(pend_sw_save), 4096);
        chk(sw_done && !run_valid, "R8 done after sw run", int'(sw_done), 1);
        serve(g, op, sw, swd);
        chk(g == 12 && pend_sw_save == 0, "R11 runs again", g, 12);

        finish_run();
    end

endmodule